// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller Core

This core gathers eight interrupt request lines into a pending register, filters them through a per-line mask and picks one winner. It raises `int_o` when that winner may interrupt the processor. On an acknowledge strobe it reports the winner's level on `vec_o`, marks that level as in service and drops its pending bit. Software drives the core through a byte-wide write port that carries three command words, selected by `wr_sel_i`. It reads back the pending register, the in-service register or a poll result on `rd_data_o`.

The priority ring is not fixed. A priority pointer names the lowest-priority level, and the ring runs upward from the level above it. End-of-interrupt commands can move the pointer to the level they retire. A set-priority command can place it anywhere. In automatic end-of-interrupt operation, each acknowledge can move it as well. Special mask mode lets lower-priority levels interrupt a handler that is still running. The poll command lets software service interrupts without an acknowledge cycle.

Top module: `pic_core`

## Requirements
- R1: After reset, `int_o` is 0, `vec_o` is 7, `rd_data_o` reads the pending register in active-low form (0xFF), no level is masked or in service, and level 0 has the highest priority, descending to level 7.
- R2: With `EDGE_TRIG`=1, a rising edge on `irq_i[n]` sampled at a clock edge sets pending bit n from that edge on. The bit stays set until the level is acknowledged. `vec_o` shows the winning level while `int_o` is high.
- R3: A write with `wr_sel_i`=0 loads the mask: data bit n = 1 masks line n and 0 unmasks it. A masked pending line never raises `int_o`.
- R4: A cycle with `inta_i`=1 and `int_o`=1 sets the winner's in-service bit (unless `auto_eoi_i`=1) and clears its pending bit. Pending readback is active-low: bit n = 0 means line n is pending. When `int_o`=0, `vec_o` is 7.
- R5: Outside special mask mode, `int_o` is 1 only when the best pending unmasked level ranks strictly above every in-service level.
- R6: With `wr_sel_i`=1, opcode bits 7:5 = 001 clear the in-service bit that has the highest current priority. Opcode 011 clears the in-service bit named by bits 2:0.
- R7: Opcode 101 acts as 001 and opcode 111 acts as 011. In both cases the retired level then becomes the lowest priority, and the level above it becomes the highest.
- R8: Opcode 110 makes the level in bits 2:0 the lowest priority without touching the in-service bits. Opcode 010 changes nothing.
- R9: With `auto_eoi_i`=1, an acknowledge leaves the in-service register unchanged. After opcode 100, each such acknowledge makes the acknowledged level the lowest priority. Opcode 000 stops this.
- R10: With `wr_sel_i`=2, bits 6:5 = 11 enter special mask mode and 10 leave it; 00 and 01 keep the mode. In the mode, any unmasked pending level whose in-service bit is clear raises `int_o`.
- R11: In the same word, bits 1:0 = 10 select pending readback and 11 select in-service readback (bit n = level n); 00 and 01 keep the current selection.
- R12: Bit 2 of that word arms a poll. While armed, `rd_data_o` is {1, 0000, level} for the winning level, or 0x00 when `int_o`=0. A cycle with `rd_en_i`=1 disarms the poll and acknowledges the reported level as in R4.
- R13: When an acknowledge and an end-of-interrupt command fall in the same cycle, both take effect. The command acts on the in-service register as it was before that cycle, and the newly acknowledged bit survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Interrupt request lines |
| inta_i | input | 1 | Acknowledge strobe, one cycle |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt operation |
| wr_en_i | input | 1 | Command word write strobe |
| wr_sel_i | input | 2 | Word select: 0 mask, 1 priority/EOI, 2 mode/poll/readback, 3 ignored |
| wr_data_i | input | 8 | Command word |
| rd_en_i | input | 1 | Read strobe; ends an armed poll |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 3 | Winning level, 7 when idle |
| rd_data_o | output | 8 | Readback: pending (active low), in-service or poll byte |

## Verification
An acknowledge and a priority-word end-of-interrupt can land on the same clock edge. Both update the in-service register, and the non-specific form chooses its target from that register's old contents. The bench sets up level 3 in service with level 1 pending, then raises `inta_i` together with a non-specific end-of-interrupt write. The expected in-service readback afterwards is only level 1. A poll read that coincides with pending-bit clearing is judged in the same way, through the poll byte and the in-service register that follows it.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int N_IRQ  = 8;
  localparam int LVL_W  = $clog2(N_IRQ);
  localparam int WORD_W = 8;

  typedef enum logic [1:0] {
    PORT_MASK = 2'd0,
    PORT_PRIO = 2'd1,
    PORT_MODE = 2'd2,
    PORT_NONE = 2'd3
  } port_e;

  typedef enum logic [2:0] {
    OP_AROT_OFF = 3'b000,
    OP_EOI_NS   = 3'b001,
    OP_NOP      = 3'b010,
    OP_EOI_SP   = 3'b011,
    OP_AROT_ON  = 3'b100,
    OP_ROT_NS   = 3'b101,
    OP_SET_LOW  = 3'b110,
    OP_ROT_SP   = 3'b111
  } prio_op_e;

  typedef struct packed {
    logic             mask_we;
    logic [N_IRQ-1:0] mask;
    logic             eoi_ns;
    logic             eoi_sp;
    logic             rot;
    logic             set_low;
    logic [LVL_W-1:0] lvl;
    logic             arot_on;
    logic             arot_off;
    logic             smm_on;
    logic             smm_off;
    logic             poll;
    logic             rsel_we;
    logic             rsel_isr;
  } pic_cmd_t;
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch
  import pic_pkg::*;
#(
  parameter int N         = N_IRQ,
  parameter bit EDGE_TRIG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  if (EDGE_TRIG) begin : g_edge
    logic [N-1:0] irq_q, irr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irq_q <= '0;
        irr_q <= '0;
      end else begin
        irq_q <= irq_i;
        irr_q <= (irr_q | (irq_i & ~irq_q)) & ~clr_i;
      end
    end
    assign irr_o = irr_q;

    assert_edge_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((irr_o & $past(irq_i & ~irq_q & ~clr_i)) == $past(irq_i & ~irq_q & ~clr_i)));
  end else begin : g_level
    logic [N-1:0] irr_q;
    // sampled line, dropped for one cycle after acknowledge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irr_q <= '0;
      else         irr_q <= irq_i & ~clr_i;
    end
    assign irr_o = irr_q;
  end
endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick
  import pic_pkg::*;
#(
  parameter int N = N_IRQ,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] low_i,
  output logic         any_o,
  output logic [W-1:0] lvl_o
);
  // scan from lowest priority upward; last hit is the highest priority
  always_comb begin
    lvl_o = '0;
    for (int k = N; k >= 1; k--) begin
      if (req_i[(int'(low_i) + k) % N]) lvl_o = W'((int'(low_i) + k) % N);
    end
    any_o = |req_i;
  end

  always_comb begin
    if (any_o) begin
      assert_pick_valid_R4: assert (req_i[lvl_o]);
    end
  end
endmodule

// File: rtl/pic_cmd_dec.sv
module pic_cmd_dec
  import pic_pkg::*;
(
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output pic_cmd_t          cmd_o
);
  prio_op_e op;
  assign op = prio_op_e'(wr_data_i[7:5]);

  always_comb begin
    cmd_o      = '0;
    cmd_o.lvl  = wr_data_i[LVL_W-1:0];
    cmd_o.mask = wr_data_i[N_IRQ-1:0];
    if (wr_en_i) begin
      case (port_e'(wr_sel_i))
        PORT_MASK: cmd_o.mask_we = 1'b1;
        PORT_PRIO: begin
          case (op)
            OP_AROT_OFF: cmd_o.arot_off = 1'b1;
            OP_AROT_ON:  cmd_o.arot_on  = 1'b1;
            OP_EOI_NS:   cmd_o.eoi_ns   = 1'b1;
            OP_EOI_SP:   cmd_o.eoi_sp   = 1'b1;
            OP_ROT_NS: begin
              cmd_o.eoi_ns = 1'b1;
              cmd_o.rot    = 1'b1;
            end
            OP_ROT_SP: begin
              cmd_o.eoi_sp = 1'b1;
              cmd_o.rot    = 1'b1;
            end
            OP_SET_LOW:  cmd_o.set_low  = 1'b1;
            default: ;
          endcase
        end
        PORT_MODE: begin
          cmd_o.smm_on   = (wr_data_i[6:5] == 2'b11);
          cmd_o.smm_off  = (wr_data_i[6:5] == 2'b10);
          cmd_o.poll     = wr_data_i[2];
          cmd_o.rsel_we  = wr_data_i[1];
          cmd_o.rsel_isr = wr_data_i[0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
#(
  parameter bit EDGE_TRIG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              inta_i,
  input  logic              auto_eoi_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic              int_o,
  output logic [LVL_W-1:0]  vec_o,
  output logic [WORD_W-1:0] rd_data_o
);
  localparam int PAD_W = WORD_W - LVL_W - 1;

  pic_cmd_t         cmd;
  logic [N_IRQ-1:0] irr, imr_q, isr_q, isr_d, cand, elig, ack_oh, eoi_clr;
  logic [LVL_W-1:0] low_q, low_d, win;
  logic             smm_q, arot_q, poll_q, rsel_isr_q;
  logic             req_any, smm_any, isr_any, ack, poll_rd;
  logic [LVL_W-1:0] req_lvl, smm_lvl, isr_lvl;

  function automatic logic [LVL_W-1:0] rank(input logic [LVL_W-1:0] lvl,
                                            input logic [LVL_W-1:0] low);
    return lvl - low - LVL_W'(1);
  endfunction

  pic_cmd_dec u_dec (
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .cmd_o    (cmd)
  );

  pic_req_latch #(.N(N_IRQ), .EDGE_TRIG(EDGE_TRIG)) u_req (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .irq_i (irq_i),
    .clr_i (ack_oh),
    .irr_o (irr)
  );

  assign cand = irr & ~imr_q;
  assign elig = cand & ~isr_q;

  pic_prio_pick #(.N(N_IRQ)) u_pick_req (.req_i(cand),  .low_i(low_q), .any_o(req_any), .lvl_o(req_lvl));
  pic_prio_pick #(.N(N_IRQ)) u_pick_smm (.req_i(elig),  .low_i(low_q), .any_o(smm_any), .lvl_o(smm_lvl));
  pic_prio_pick #(.N(N_IRQ)) u_pick_isr (.req_i(isr_q), .low_i(low_q), .any_o(isr_any), .lvl_o(isr_lvl));

  always_comb begin
    if (smm_q) begin
      win   = smm_lvl;
      int_o = smm_any;
    end else begin
      win   = req_lvl;
      int_o = req_any && (!isr_any || (rank(req_lvl, low_q) < rank(isr_lvl, low_q)));
    end
  end

  assign vec_o   = int_o ? win : '1;
  assign poll_rd = rd_en_i & poll_q;
  assign ack     = (inta_i | poll_rd) & int_o;
  assign ack_oh  = ack ? (N_IRQ'(1) << win) : '0;

  always_comb begin
    eoi_clr = '0;
    if (cmd.eoi_ns && isr_any) eoi_clr = N_IRQ'(1) << isr_lvl;
    if (cmd.eoi_sp)            eoi_clr = N_IRQ'(1) << cmd.lvl;
    // EOI acts on the old contents; a same-cycle acknowledge survives
    isr_d = (isr_q & ~eoi_clr) | (auto_eoi_i ? '0 : ack_oh);
  end

  always_comb begin
    low_d = low_q;
    if (cmd.set_low)                         low_d = cmd.lvl;
    else if (cmd.rot && cmd.eoi_sp)          low_d = cmd.lvl;
    else if (cmd.rot && cmd.eoi_ns)          low_d = isr_any ? isr_lvl : low_q;
    else if (ack && auto_eoi_i && arot_q)    low_d = win;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imr_q      <= '0;
      isr_q      <= '0;
      low_q      <= LVL_W'(N_IRQ - 1);
      smm_q      <= 1'b0;
      arot_q     <= 1'b0;
      poll_q     <= 1'b0;
      rsel_isr_q <= 1'b0;
    end else begin
      isr_q <= isr_d;
      low_q <= low_d;
      if (cmd.mask_we) imr_q <= cmd.mask;
      if (cmd.smm_on)       smm_q <= 1'b1;
      else if (cmd.smm_off) smm_q <= 1'b0;
      if (cmd.arot_on)       arot_q <= 1'b1;
      else if (cmd.arot_off) arot_q <= 1'b0;
      if (cmd.poll)         poll_q <= 1'b1;
      else if (rd_en_i)     poll_q <= 1'b0;
      if (cmd.rsel_we) rsel_isr_q <= cmd.rsel_isr;
    end
  end

  always_comb begin
    if (poll_q)          rd_data_o = {int_o, {PAD_W{1'b0}}, (int_o ? win : LVL_W'(0))};
    else if (rsel_isr_q) rd_data_o = WORD_W'(isr_q);
    else                 rd_data_o = WORD_W'(~irr);
  end

  assert_mask_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> !imr_q[vec_o]);

  assert_nest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_o && !smm_q) |-> !isr_q[vec_o]);

  assert_smm_free_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_o && smm_q) |-> (irr[vec_o] && !isr_q[vec_o]));

  assert_ack_sets_isr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && int_o && !auto_eoi_i && !wr_en_i) |=> isr_q[$past(vec_o)]);

  assert_aeoi_keeps_isr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && auto_eoi_i && !wr_en_i) |=> (isr_q == $past(isr_q)));

  assert_nseoi_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd1 && wr_data_i[7:5] == 3'b001 && !inta_i && !rd_en_i)
    |=> ($countones(isr_q) == $countones($past(isr_q)) - int'(|$past(isr_q))));

  assert_set_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd1 && wr_data_i[7:5] == 3'b110) |=> (low_q == $past(wr_data_i[2:0])));

  assert_poll_ends_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !(wr_en_i && wr_sel_i == 2'd2 && wr_data_i[2])) |=> !poll_q);
endmodule

// File: tb/pic_core_tb.sv
`timescale 1ns/1ps
module pic_core_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] irq_i = '0;
  logic       inta_i = 1'b0;
  logic       auto_eoi_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       rd_en_i = 1'b0;
  logic       int_o;
  logic [2:0] vec_o;
  logic [7:0] rd_data_o;

  pic_core u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .inta_i(inta_i),
    .auto_eoi_i(auto_eoi_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .int_o(int_o), .vec_o(vec_o),
    .rd_data_o(rd_data_o)
  );

  always #4 clk_i = ~clk_i;

  localparam int K_INT = 0, K_VEC = 1, K_RD = 2;
  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // monitor: compare every queued expectation mid-cycle
  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        K_INT:   act = {7'd0, int_o};
        K_VEC:   act = {5'd0, vec_o};
        default: act = rd_data_o;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic cyc();
    @(posedge clk_i);
    #1;
  endtask

  task automatic expect_val(input int kind, input logic [7:0] exp, input string tag);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  task automatic pulse(input logic [7:0] m);
    irq_i = irq_i | m;
    cyc();
    irq_i = irq_i & ~m;
    cyc();
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    cyc();
    wr_en_i = 1'b0;
  endtask

  task automatic ack(input logic [2:0] v, input string tag);
    inta_i = 1'b1;
    expect_val(K_VEC, {5'd0, v}, tag);
    cyc();
    inta_i = 1'b0;
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    // R1 reset state
    expect_val(K_INT, 8'h00, "R1 int after reset");
    expect_val(K_VEC, 8'h07, "R1 idle vec");
    expect_val(K_RD,  8'hFF, "R1 pending readback");
    cyc();

    // R2 edge capture
    pulse(8'h08);
    expect_val(K_INT, 8'h01, "R2 int on edge");
    expect_val(K_VEC, 8'h03, "R2 vec");
    expect_val(K_RD,  8'hF7, "R11 active-low pending");
    cyc();

    // R3 mask
    wr(2'd0, 8'h08);
    expect_val(K_INT, 8'h00, "R3 masked");
    wr(2'd0, 8'h00);
    expect_val(K_INT, 8'h01, "R3 unmasked");

    // R4 acknowledge
    pulse(8'h20);
    expect_val(K_VEC, 8'h03, "R4 fixed order");
    ack(3'd3, "R4 ack vec");
    wr(2'd2, 8'h0B);
    expect_val(K_RD,  8'h08, "R4 isr set");
    expect_val(K_INT, 8'h00, "R5 lower blocked");
    wr(2'd2, 8'h0A);
    expect_val(K_RD,  8'hDF, "R4 pending cleared");

    // R5 nesting
    pulse(8'h02);
    expect_val(K_INT, 8'h01, "R5 higher nests");
    expect_val(K_VEC, 8'h01, "R5 vec");
    ack(3'd1, "R5 ack");
    wr(2'd2, 8'h0B);
    expect_val(K_RD, 8'h0A, "R5 isr two");

    // R6 EOI
    wr(2'd1, 8'h20);
    expect_val(K_RD,  8'h08, "R6 nonspecific");
    expect_val(K_INT, 8'h00, "R6 still blocked");
    wr(2'd1, 8'h63);
    expect_val(K_RD,  8'h00, "R6 specific");
    expect_val(K_VEC, 8'h05, "R6 pending 5 wins");
    ack(3'd5, "R6 ack 5");
    expect_val(K_RD, 8'h20, "R6 isr 5");
    wr(2'd1, 8'h20);
    expect_val(K_RD, 8'h00, "R6 cleared");

    // R7 rotation on EOI
    pulse(8'h04);
    ack(3'd2, "R7 ack 2");
    wr(2'd1, 8'hA0);
    expect_val(K_RD, 8'h00, "R7 rotate ns clears");
    pulse(8'h0D);
    expect_val(K_VEC, 8'h03, "R7 after rotate ns");
    ack(3'd3, "R7 ack 3");
    wr(2'd1, 8'hE3);
    expect_val(K_RD,  8'h00, "R7 rotate sp clears");
    expect_val(K_VEC, 8'h00, "R7 after rotate sp");

    // R8 set priority / no-op
    wr(2'd1, 8'hC0);
    expect_val(K_VEC, 8'h02, "R8 set low 0");
    wr(2'd1, 8'h45);
    expect_val(K_VEC, 8'h02, "R8 nop");
    expect_val(K_RD,  8'h00, "R8 nop isr");
    ack(3'd2, "R8 ack 2");
    expect_val(K_INT, 8'h00, "R8 level 0 lowest");
    wr(2'd1, 8'h20);
    expect_val(K_VEC, 8'h00, "R8 level 0 after eoi");
    ack(3'd0, "R8 ack 0");
    wr(2'd1, 8'h20);
    wr(2'd1, 8'hC7);

    // R11 keep selection
    wr(2'd2, 8'h08);
    expect_val(K_RD, 8'h00, "R11 selection kept");

    // R10 special mask mode
    pulse(8'h10);
    ack(3'd4, "R10 ack 4");
    expect_val(K_RD, 8'h10, "R10 isr 4");
    pulse(8'h40);
    expect_val(K_INT, 8'h00, "R10 normal blocks");
    wr(2'd2, 8'h68);
    expect_val(K_INT, 8'h01, "R10 smm int");
    expect_val(K_VEC, 8'h06, "R10 smm vec");
    pulse(8'h10);
    expect_val(K_VEC, 8'h06, "R10 in-service excluded");
    wr(2'd2, 8'h28);
    expect_val(K_INT, 8'h01, "R10 01 keeps mode");
    wr(2'd2, 8'h48);
    expect_val(K_INT, 8'h00, "R10 left mode");
    wr(2'd1, 8'h20);
    expect_val(K_VEC, 8'h04, "R10 after eoi");
    ack(3'd4, "R10 ack 4b");
    wr(2'd1, 8'h20);
    ack(3'd6, "R10 ack 6");
    wr(2'd1, 8'h20);
    expect_val(K_RD, 8'h00, "R10 clean");

    // R12 poll
    pulse(8'h80);
    wr(2'd2, 8'h0C);
    rd_en_i = 1'b1;
    expect_val(K_RD, 8'h87, "R12 poll byte");
    cyc();
    rd_en_i = 1'b0;
    expect_val(K_RD,  8'h80, "R12 poll acknowledged");
    expect_val(K_INT, 8'h00, "R12 no int after poll");
    wr(2'd1, 8'h20);
    wr(2'd2, 8'h0C);
    rd_en_i = 1'b1;
    expect_val(K_RD, 8'h00, "R12 empty poll");
    cyc();
    rd_en_i = 1'b0;
    expect_val(K_RD, 8'h00, "R12 back to isr");

    // R9 automatic EOI
    auto_eoi_i = 1'b1;
    pulse(8'h04);
    ack(3'd2, "R9 ack 2");
    expect_val(K_RD,  8'h00, "R9 isr untouched");
    expect_val(K_INT, 8'h00, "R9 idle");
    wr(2'd1, 8'h80);
    pulse(8'h22);
    expect_val(K_VEC, 8'h01, "R9 default order");
    ack(3'd1, "R9 ack 1");
    pulse(8'h01);
    expect_val(K_VEC, 8'h05, "R9 rotated on ack");
    wr(2'd1, 8'h00);
    ack(3'd5, "R9 ack 5");
    pulse(8'h04);
    expect_val(K_VEC, 8'h02, "R9 rotation off");
    ack(3'd2, "R9 ack 2b");
    ack(3'd0, "R9 ack 0");
    auto_eoi_i = 1'b0;
    wr(2'd1, 8'hC7);

    // R13 acknowledge with EOI in one cycle
    pulse(8'h08);
    ack(3'd3, "R13 ack 3");
    pulse(8'h02);
    expect_val(K_VEC, 8'h01, "R13 nested vec");
    inta_i = 1'b1;
    wr_en_i = 1'b1; wr_sel_i = 2'd1; wr_data_i = 8'h20;
    cyc();
    inta_i = 1'b0;
    wr_en_i = 1'b0;
    expect_val(K_RD,  8'h02, "R13 both applied");
    expect_val(K_INT, 8'h00, "R13 idle");

    repeat (3) cyc();
    done = 1'b1;
    report();
    $finish;
  end
endmodule